// File: doc/BRIEF.md
# Wrapping Burst Request Splitter

This block sits between a host-side burst source and the command port of an external NOR or PSRAM memory controller. Each request carries a byte address, a burst kind (incrementing or wrapping), a beat count and, through static configuration inputs, the memory data width, the access mode and the memory's wrap setting. The two top address bits select one of four chip-select banks. The lower bits become a memory word address, scaled to the data width.

Incrementing bursts go out as one linear command. A wrapping burst goes out as one wrapping command when the memory can sequence the wrap itself. That is the case in asynchronous mode, where every beat carries its own address. It is also the case in synchronous mode when memory wrap support is on and the memory wrap length equals the burst length. Otherwise the wrapping burst is rewritten as two linear commands. The first runs from the start word to the end of the wrap window. The second runs from the window base for the beats that remain. Both sides use a valid/ready handshake. Configuration is sampled in the cycle a request is accepted.

Top module: `burst_wrap_splitter`

## Requirements
- R1: Request address bits [27:26] select the bank: value k asserts only `cmd_cs[k]` (00 gives bit 0, 11 gives bit 3), and every command carries exactly one asserted chip-select bit.
- R2: With `cfg_bus16` = 0 (8-bit memory), `cmd_addr` equals request address bits [25:0].
- R3: With `cfg_bus16` = 1 (16-bit memory), `cmd_addr` equals request address bits [25:1], zero-extended, which is the byte address shifted right by one.
- R4: An incrementing request (`req_wrap` = 0) produces one command with `cmd_wrap` = 0, `cmd_len` equal to the beat count and `cmd_addr` equal to the start word.
- R5: With `cfg_sync_mode` = 1 and `cfg_wrap_en` = 1, a wrapping request whose beat count equals the memory wrap length (8 when `cfg_wrap16` = 0, 16 when 1) produces one command with `cmd_wrap` = 1, the start word as `cmd_addr` and the beat count as `cmd_len`.
- R6: In synchronous mode, a wrapping request of B beats (a power of two) is split when wrap support is off or B differs from the memory wrap length. With offset O = start word mod B and O ≠ 0, the block emits two linear commands in this order: (start word, B − O), then (start word with its low log2(B) bits cleared, O).
- R7: In the split case of R6 with O = 0, only one linear command (start word, B) is emitted, and no command ever has `cmd_len` = 0.
- R8: With `cfg_sync_mode` = 0 (asynchronous), a wrapping request produces one command with `cmd_wrap` = 1, regardless of `cfg_wrap_en` and the wrap length.
- R9: `req_ready` is low from the cycle after a request is accepted until its last command has been accepted, so no new request is taken between the two halves of a split.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` and all command fields hold their values into the next cycle.
- R11: In the cycle after a cycle with `rst_n` low, `cmd_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bus16 | input | 1 | Memory data width: 0 for 8-bit, 1 for 16-bit |
| cfg_sync_mode | input | 1 | 1 for synchronous burst mode, 0 for asynchronous |
| cfg_wrap_en | input | 1 | Memory wrap support enabled |
| cfg_wrap16 | input | 1 | Memory wrap length: 0 for 8 words, 1 for 16 words |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with `req_valid` |
| req_addr | input | 28 | Host byte address; bits [27:26] pick the bank |
| req_wrap | input | 1 | Burst kind: 1 wrapping, 0 incrementing |
| req_beats | input | 8 | Beat count, at least 1; a power of two for wrapping bursts |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Command accepted when high together with `cmd_valid` |
| cmd_cs | output | 4 | One-hot chip-select |
| cmd_addr | output | 26 | Memory word address |
| cmd_len | output | 8 | Command length in beats |
| cmd_wrap | output | 1 | 1 for a wrapping command, 0 for linear |

## Verification
The bench walks wrapping bursts through every decision branch: a matching wrap length, wrap support off, a mismatched length in both directions, asynchronous mode, and a window offset of zero. A design that swapped the two halves, used the start word for the second half or emitted a zero-length tail shows up as a mismatched or extra command in the scoreboard. Requests are queued back to back while the command side stalls on an irregular pattern. A design that raised `req_ready` between split halves, or let fields move during a stall, would lose ordering or change a held value. Both data widths are driven with an odd byte address, which catches a missing or doubled shift.

// File: rtl/burst_split_pkg.sv
// Package: shared types for the wrapping burst splitter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package burst_split_pkg;

    // Sequencer position while a request's commands are being issued.
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_FIRST  = 2'd1,
        SQ_SECOND = 2'd2
    } seq_state_e;

    // How one accepted request is turned into commands.
    typedef enum logic [1:0] {
        PLAN_LINEAR = 2'd0,   // one linear command
        PLAN_WRAP   = 2'd1,   // one wrapping command
        PLAN_SPLIT  = 2'd2    // two linear commands
    } plan_e;

endpackage

// File: rtl/bsplit_addr_map.sv
// Module: bsplit_addr_map
// Decodes the bank select field of a host byte address into a one-hot
// chip-select and converts the in-bank byte offset into a memory word
// address for an 8-bit or 16-bit wide memory.
// Assumes ADDR_W == OFS_W + $clog2(BANKS) and BANKS a power of two.
module bsplit_addr_map #(
    parameter int ADDR_W = 28,
    parameter int OFS_W  = 26,
    parameter int BANKS  = 4
) (
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              bus16,
    output logic [BANKS-1:0]  cs_onehot,
    output logic [OFS_W-1:0]  word_addr
);
    localparam int BANK_W = $clog2(BANKS);

    logic [BANK_W-1:0] bank_idx;

    assign bank_idx = byte_addr[ADDR_W-1 -: BANK_W];

    // One comparator per bank drives that bank's select line.
    for (genvar b = 0; b < BANKS; b++) begin : g_cs
        assign cs_onehot[b] = (bank_idx == BANK_W'(b));
    end

    // Word address: byte offset as is, or halved for a 16-bit memory.
    always_comb begin
        if (bus16) begin
            word_addr = {1'b0, byte_addr[OFS_W-1:1]};
        end else begin
            word_addr = byte_addr[OFS_W-1:0];
        end
    end

endmodule

// File: rtl/bsplit_planner.sv
// Module: bsplit_planner
// Purely combinational. Decides whether a request becomes one linear,
// one wrapping or two linear commands, and computes the address and
// length of each.
// Assumes: beats >= 1; for wrapping bursts beats is a power of two and
// fits in LEN_W bits; OFS_W > LEN_W.
module bsplit_planner
    import burst_split_pkg::*;
#(
    parameter int OFS_W = 26,
    parameter int LEN_W = 8
) (
    input  logic [OFS_W-1:0] word_addr,
    input  logic [LEN_W-1:0] beats,
    input  logic             is_wrap,
    input  logic             sync_mode,
    input  logic             wrap_en,
    input  logic             wrap16,
    output logic             two_cmds,
    output logic [OFS_W-1:0] c0_addr,
    output logic [LEN_W-1:0] c0_len,
    output logic             c0_wrap,
    output logic [OFS_W-1:0] c1_addr,
    output logic [LEN_W-1:0] c1_len
);
    localparam logic [LEN_W-1:0] WRAP_SHORT = LEN_W'(8);
    localparam logic [LEN_W-1:0] WRAP_LONG  = LEN_W'(16);

    logic [LEN_W-1:0] win_mask;
    logic [LEN_W-1:0] offset;
    logic [OFS_W-1:0] win_base;
    logic [LEN_W-1:0] mem_wrap_len;
    logic             mem_can_wrap;
    plan_e            plan;

    // Window geometry: mask of in-window bits, start offset and window base.
    always_comb begin
        win_mask = beats - LEN_W'(1);
        offset   = word_addr[LEN_W-1:0] & win_mask;
        win_base = word_addr & ~{{(OFS_W-LEN_W){1'b0}}, win_mask};
    end

    // Decide whether the memory can sequence the wrap on its own.
    always_comb begin
        mem_wrap_len = wrap16 ? WRAP_LONG : WRAP_SHORT;
        mem_can_wrap = !sync_mode || (wrap_en && (beats == mem_wrap_len));
    end

    // Select the plan for this request.
    always_comb begin
        if (!is_wrap) begin
            plan = PLAN_LINEAR;
        end else if (mem_can_wrap) begin
            plan = PLAN_WRAP;
        end else if (offset == '0) begin
            plan = PLAN_LINEAR;
        end else begin
            plan = PLAN_SPLIT;
        end
    end

    // Build the first and second command fields from the plan.
    always_comb begin
        c0_addr  = word_addr;
        c0_len   = beats;
        c0_wrap  = 1'b0;
        c1_addr  = win_base;
        c1_len   = offset;
        two_cmds = 1'b0;
        case (plan)
            PLAN_WRAP:  c0_wrap = 1'b1;
            PLAN_SPLIT: begin
                c0_len   = beats - offset;
                two_cmds = 1'b1;
            end
            default:    c0_wrap = 1'b0;
        endcase
    end

endmodule

// File: rtl/bsplit_sequencer.sv
// Module: bsplit_sequencer
// Registers the planned command(s) when a request is accepted and hands
// them out one at a time on the command port. The request side is held
// off until the last command of the current request is accepted.
// Assumes the planned fields are valid whenever req_valid is high.
module bsplit_sequencer
    import burst_split_pkg::*;
#(
    parameter int CS_W  = 4,
    parameter int OFS_W = 26,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CS_W-1:0]  in_cs,
    input  logic             in_two,
    input  logic [OFS_W-1:0] in_c0_addr,
    input  logic [LEN_W-1:0] in_c0_len,
    input  logic             in_c0_wrap,
    input  logic [OFS_W-1:0] in_c1_addr,
    input  logic [LEN_W-1:0] in_c1_len,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [CS_W-1:0]  cmd_cs,
    output logic [OFS_W-1:0] cmd_addr,
    output logic [LEN_W-1:0] cmd_len,
    output logic             cmd_wrap
);
    seq_state_e       state;
    logic             take_req;
    logic             cmd_fire;
    logic [CS_W-1:0]  r_cs;
    logic             r_two;
    logic [OFS_W-1:0] r_c0_addr;
    logic [LEN_W-1:0] r_c0_len;
    logic             r_c0_wrap;
    logic [OFS_W-1:0] r_c1_addr;
    logic [LEN_W-1:0] r_c1_len;

    assign req_ready = (state == SQ_IDLE);
    assign take_req  = req_valid && req_ready;
    assign cmd_valid = (state != SQ_IDLE);
    assign cmd_fire  = cmd_valid && cmd_ready;

    // State walk: idle, first command, optional second command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
        end else begin
            case (state)
                SQ_IDLE:   if (take_req) state <= SQ_FIRST;
                SQ_FIRST:  if (cmd_fire) state <= r_two ? SQ_SECOND : SQ_IDLE;
                SQ_SECOND: if (cmd_fire) state <= SQ_IDLE;
                default:   state <= SQ_IDLE;
            endcase
        end
    end

    // Capture both planned commands at request acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_cs      <= '0;
            r_two     <= 1'b0;
            r_c0_addr <= '0;
            r_c0_len  <= '0;
            r_c0_wrap <= 1'b0;
            r_c1_addr <= '0;
            r_c1_len  <= '0;
        end else if (take_req) begin
            r_cs      <= in_cs;
            r_two     <= in_two;
            r_c0_addr <= in_c0_addr;
            r_c0_len  <= in_c0_len;
            r_c0_wrap <= in_c0_wrap;
            r_c1_addr <= in_c1_addr;
            r_c1_len  <= in_c1_len;
        end
    end

    // Present the command that matches the current state.
    always_comb begin
        cmd_cs = r_cs;
        if (state == SQ_SECOND) begin
            cmd_addr = r_c1_addr;
            cmd_len  = r_c1_len;
            cmd_wrap = 1'b0;
        end else begin
            cmd_addr = r_c0_addr;
            cmd_len  = r_c0_len;
            cmd_wrap = r_c0_wrap;
        end
    end

endmodule

// File: rtl/burst_wrap_splitter.sv
// Module: burst_wrap_splitter (top)
// Turns a host burst request into one or two memory burst commands:
// bank decode, byte-to-word address conversion, and wrap pass-through
// or split into two linear commands.
// Assumes configuration inputs are stable around request acceptance,
// req_beats >= 1, and wrapping bursts use a power-of-two beat count.
module burst_wrap_splitter #(
    parameter int ADDR_W = 28,
    parameter int BANKS  = 4,
    parameter int LEN_W  = 8,
    parameter int OFS_W  = ADDR_W - $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bus16,
    input  logic              cfg_sync_mode,
    input  logic              cfg_wrap_en,
    input  logic              cfg_wrap16,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_wrap,
    input  logic [LEN_W-1:0]  req_beats,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [BANKS-1:0]  cmd_cs,
    output logic [OFS_W-1:0]  cmd_addr,
    output logic [LEN_W-1:0]  cmd_len,
    output logic              cmd_wrap
);
    logic [BANKS-1:0] dec_cs;
    logic [OFS_W-1:0] dec_word;
    logic             pl_two;
    logic [OFS_W-1:0] pl_c0_addr;
    logic [LEN_W-1:0] pl_c0_len;
    logic             pl_c0_wrap;
    logic [OFS_W-1:0] pl_c1_addr;
    logic [LEN_W-1:0] pl_c1_len;

    bsplit_addr_map #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .BANKS  (BANKS)
    ) u_map (
        .byte_addr (req_addr),
        .bus16     (cfg_bus16),
        .cs_onehot (dec_cs),
        .word_addr (dec_word)
    );

    bsplit_planner #(
        .OFS_W (OFS_W),
        .LEN_W (LEN_W)
    ) u_plan (
        .word_addr (dec_word),
        .beats     (req_beats),
        .is_wrap   (req_wrap),
        .sync_mode (cfg_sync_mode),
        .wrap_en   (cfg_wrap_en),
        .wrap16    (cfg_wrap16),
        .two_cmds  (pl_two),
        .c0_addr   (pl_c0_addr),
        .c0_len    (pl_c0_len),
        .c0_wrap   (pl_c0_wrap),
        .c1_addr   (pl_c1_addr),
        .c1_len    (pl_c1_len)
    );

    bsplit_sequencer #(
        .CS_W  (BANKS),
        .OFS_W (OFS_W),
        .LEN_W (LEN_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .in_cs      (dec_cs),
        .in_two     (pl_two),
        .in_c0_addr (pl_c0_addr),
        .in_c0_len  (pl_c0_len),
        .in_c0_wrap (pl_c0_wrap),
        .in_c1_addr (pl_c1_addr),
        .in_c1_len  (pl_c1_len),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_cs     (cmd_cs),
        .cmd_addr   (cmd_addr),
        .cmd_len    (cmd_len),
        .cmd_wrap   (cmd_wrap)
    );

endmodule

// File: rtl/bsplit_checker.sv
// Module: bsplit_checker
// Port-level protocol properties of burst_wrap_splitter, bound to it below.
// Assumes the environment never issues a request with zero beats.
module bsplit_checker #(
    parameter int CS_W  = 4,
    parameter int OFS_W = 26,
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic [CS_W-1:0]  cmd_cs,
    input logic [OFS_W-1:0] cmd_addr,
    input logic [LEN_W-1:0] cmd_len,
    input logic             cmd_wrap
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_cs) == 1)); // R1

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_len != '0)); // R7

    AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready); // R9

    AST_REQ_YIELDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> cmd_valid); // R9

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_cs) && $stable(cmd_addr)
                                       && $stable(cmd_len) && $stable(cmd_wrap))); // R10

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && req_ready)); // R11

endmodule

bind burst_wrap_splitter bsplit_checker #(
    .CS_W  (BANKS),
    .OFS_W (OFS_W),
    .LEN_W (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_cs    (cmd_cs),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_wrap  (cmd_wrap)
);

// File: tb/tb_burst_wrap_splitter.sv
`timescale 1ns/1ps
module tb_burst_wrap_splitter;

    localparam int ADDR_W = 28;
    localparam int LEN_W  = 8;
    localparam int OFS_W  = 26;
    localparam int WD_LIMIT = 20000;

    typedef struct packed {
        logic [3:0]       cs;
        logic [OFS_W-1:0] addr;
        logic [LEN_W-1:0] len;
        logic             wrap;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_bus16 = 1'b0;
    logic              cfg_sync_mode = 1'b1;
    logic              cfg_wrap_en = 1'b1;
    logic              cfg_wrap16 = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_wrap = 1'b0;
    logic [LEN_W-1:0]  req_beats = 8'd1;
    logic              cmd_valid;
    logic              cmd_ready = 1'b1;
    logic [3:0]        cmd_cs;
    logic [OFS_W-1:0]  cmd_addr;
    logic [LEN_W-1:0]  cmd_len;
    logic              cmd_wrap;

    exp_t  exp_q[$];
    string tag_q[$];
    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    rdy_cnt = 0;
    bit    rdy_always = 1'b1;
    bit    done = 1'b0;
    bit    held_valid = 1'b0;
    exp_t  held;

    burst_wrap_splitter dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_bus16     (cfg_bus16),
        .cfg_sync_mode (cfg_sync_mode),
        .cfg_wrap_en   (cfg_wrap_en),
        .cfg_wrap16    (cfg_wrap16),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_wrap      (req_wrap),
        .req_beats     (req_beats),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_cs        (cmd_cs),
        .cmd_addr      (cmd_addr),
        .cmd_len       (cmd_len),
        .cmd_wrap      (cmd_wrap)
    );

    always #2.5 clk = ~clk;

    // Command-side ready: always high, or an irregular stall pattern.
    always @(posedge clk) begin
        #1;
        rdy_cnt++;
        cmd_ready = rdy_always ? 1'b1 : ((rdy_cnt % 3) != 0) && ((rdy_cnt % 7) != 2);
    end

    // Expected command list for one request, built from the requirements.
    task automatic push_exp(input logic [ADDR_W-1:0] a, input logic w,
                            input logic [LEN_W-1:0] b, input string tag);
        exp_t e;
        logic [OFS_W-1:0] word;
        logic [LEN_W-1:0] nmem;
        logic [OFS_W-1:0] off;
        word = cfg_bus16 ? {1'b0, a[25:1]} : a[25:0];
        nmem = cfg_wrap16 ? 8'd16 : 8'd8;
        e.cs = 4'b0001 << a[27:26];
        e.addr = word;
        e.len = b;
        e.wrap = 1'b0;
        if (!w) begin
            exp_q.push_back(e); tag_q.push_back(tag);
        end else if (!cfg_sync_mode || (cfg_wrap_en && b == nmem)) begin
            e.wrap = 1'b1;
            exp_q.push_back(e); tag_q.push_back(tag);
        end else begin
            off = word % OFS_W'(b);
            if (off == 0) begin
                exp_q.push_back(e); tag_q.push_back(tag);
            end else begin
                e.len = b - off[LEN_W-1:0];
                exp_q.push_back(e); tag_q.push_back(tag);
                e.addr = word - off;
                e.len = off[LEN_W-1:0];
                exp_q.push_back(e); tag_q.push_back(tag);
            end
        end
    endtask

    // Driver: offer one request, wait for acceptance, record expectations.
    task automatic send(input logic [ADDR_W-1:0] a, input logic w,
                        input logic [LEN_W-1:0] b, input string tag);
        req_addr  = a;
        req_wrap  = w;
        req_beats = b;
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) break;
        end
        @(posedge clk);
        #1;
        push_exp(a, w, b, tag);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Monitor: scoreboard compare, stall stability and request blocking.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (exp_q.size() != 0) begin
                checks++;
                if (req_ready) begin
                    errors++;
                    $display("FAIL R9 req_ready=%0b expected 0 with %0d commands pending",
                             req_ready, exp_q.size());
                end
            end
            if (held_valid) begin
                checks++;
                if (!cmd_valid || cmd_cs != held.cs || cmd_addr != held.addr
                    || cmd_len != held.len || cmd_wrap != held.wrap) begin
                    errors++;
                    $display("FAIL R10 stalled cmd v=%0b cs=%h a=%h l=%0d w=%0b expected v=1 cs=%h a=%h l=%0d w=%0b",
                             cmd_valid, cmd_cs, cmd_addr, cmd_len, cmd_wrap,
                             held.cs, held.addr, held.len, held.wrap);
                end
            end
            held_valid = cmd_valid && !cmd_ready;
            held = '{cs: cmd_cs, addr: cmd_addr, len: cmd_len, wrap: cmd_wrap};
            if (cmd_valid && cmd_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected cmd cs=%h a=%h l=%0d w=%0b expected none",
                             cmd_cs, cmd_addr, cmd_len, cmd_wrap);
                end else begin
                    exp_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (cmd_cs != e.cs || cmd_addr != e.addr || cmd_len != e.len
                        || cmd_wrap != e.wrap) begin
                        errors++;
                        $display("FAIL %s cmd cs=%h a=%h l=%0d w=%0b expected cs=%h a=%h l=%0d w=%0b",
                                 t, cmd_cs, cmd_addr, cmd_len, cmd_wrap,
                                 e.cs, e.addr, e.len, e.wrap);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog cycles=%0d expected below %0d", cycles, WD_LIMIT);
            report();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (cmd_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R11 reset cmd_valid=%0b req_ready=%0b expected 0 1", cmd_valid, req_ready);
        end
        @(posedge clk);
        #1;

        // R1: one incrementing request to each bank.
        for (int k = 0; k < 4; k++) begin
            send({2'(k), 26'h0000100}, 1'b0, 8'd4, "R1");
        end
        drain();

        // R2 and R3: odd byte address at both widths.
        cfg_bus16 = 1'b0;
        send({2'd2, 26'h3ABCDE5}, 1'b0, 8'd1, "R2");
        drain();
        cfg_bus16 = 1'b1;
        send({2'd2, 26'h3ABCDE5}, 1'b0, 8'd1, "R3");
        drain();

        // R4: incrementing bursts never split, even from mid-window.
        cfg_bus16 = 1'b0;
        send({2'd1, 26'h0000107}, 1'b0, 8'd16, "R4");
        send({2'd3, 26'h0000203}, 1'b0, 8'd8, "R4");
        drain();

        // R5: matching wrap lengths pass as a single wrap command.
        cfg_wrap_en = 1'b1; cfg_wrap16 = 1'b0;
        send({2'd0, 26'h0000105}, 1'b1, 8'd8, "R5");
        drain();
        cfg_wrap16 = 1'b1;
        send({2'd1, 26'h000020B}, 1'b1, 8'd16, "R5");
        drain();

        // R6: wrap disabled, and both length mismatches, split in two.
        cfg_wrap_en = 1'b0; cfg_wrap16 = 1'b0;
        send({2'd0, 26'h0000105}, 1'b1, 8'd8, "R6");
        drain();
        cfg_wrap_en = 1'b1; cfg_wrap16 = 1'b1;
        send({2'd2, 26'h0000305}, 1'b1, 8'd8, "R6");
        drain();
        cfg_wrap16 = 1'b0;
        send({2'd3, 26'h000040E}, 1'b1, 8'd16, "R6");
        drain();
        cfg_bus16 = 1'b1;
        send({2'd1, 26'h000001A}, 1'b1, 8'd4, "R6");
        drain();
        cfg_bus16 = 1'b0;

        // R7: window-aligned start gives one linear command.
        cfg_wrap_en = 1'b0;
        send({2'd0, 26'h0000140}, 1'b1, 8'd8, "R7");
        drain();
        cfg_wrap_en = 1'b1; cfg_wrap16 = 1'b1;
        send({2'd1, 26'h0000120}, 1'b1, 8'd32, "R7");
        drain();

        // R8: asynchronous mode never splits.
        cfg_sync_mode = 1'b0; cfg_wrap_en = 1'b0; cfg_wrap16 = 1'b0;
        send({2'd2, 26'h0000103}, 1'b1, 8'd8, "R8");
        send({2'd3, 26'h0000109}, 1'b1, 8'd4, "R8");
        drain();
        cfg_sync_mode = 1'b1;

        // R9 and R10: back-to-back splits against a stalling command side.
        rdy_always = 1'b0;
        cfg_wrap_en = 1'b0;
        for (int i = 0; i < 12; i++) begin
            send({2'(i % 4), 26'(32'h500 + i * 37)}, 1'b1, 8'(4 << (i % 3)), "R9");
        end
        cfg_wrap_en = 1'b1; cfg_wrap16 = 1'b0;
        for (int i = 0; i < 6; i++) begin
            send({2'(i % 4), 26'(32'h900 + i * 13)}, i[0], 8'd8, "R10");
        end
        drain();
        rdy_always = 1'b1;

        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R6 leftover=%0d expected 0", exp_q.size());
        end
        report();
    end

endmodule